// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an addressing-mode code and its operands into the final memory operand address for a load or store. Each request carries a mode code, a byte/word size flag, the address of the next instruction, an instruction argument (a full word, or a signed 8-bit displacement in its low byte), a 4-bit indexed sub-mode and the value of the selected index register. The unit returns the final address and, for stepping index modes, the updated index register value together with a write enable.

Modes that go through a pointer (absolute indirect, PC-relative indirect and indexed indirect) fetch one word through a simple request/acknowledge port. The pointer address is held on the port until the acknowledge arrives. The word returned becomes the operand address. All arithmetic is 16 bits wide and wraps modulo 65536. A request is taken only while the unit is idle, and the result is reported with a single-cycle `done` pulse.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `mem_req` and `wb_en` are low.
- R2: Mode code 0 (literal) raises `done` in the cycle after `start`, with `addr` equal to `arg`. No memory request is made.
- R3: Mode code 1 (absolute) raises `done` in the cycle after `start`, with `addr` equal to `arg`. No memory request is made.
- R4: Mode code 3 (PC-relative) produces `next_pc` plus the sign-extended `arg[7:0]`, modulo 65536, in the cycle after `start`.
- R5: Mode code 2 (absolute indirect) reads the word at `arg`. Mode code 4 (PC-relative indirect) reads the word at the R4 address. `mem_req` rises in the cycle after `start` and holds `mem_addr` steady until `mem_ack` is sampled high. `done` follows one cycle after that, with `addr` equal to the `mem_rdata` taken with the acknowledge.
- R6: Mode code 5 (indexed) with `xsub[1:0]` equal to 0 or 3 uses `idx_val` as the address. `xsub[2]` adds the sign-extended `arg[7:0]`. No writeback is made.
- R7: With `xsub[1:0]` equal to 1 (post-increment), the address is formed from the unmodified `idx_val`. The writeback is `idx_val` plus the step, where the step is 1 if `size_word` is 0 and 2 if `size_word` is 1.
- R8: With `xsub[1:0]` equal to 2 (pre-decrement), `idx_val` minus the step is both the writeback and the base of the address.
- R9: In mode code 5 with `xsub[3]` set, the indexed address is used as a pointer and one word is read there, as in R5. The R7/R8 writeback is still reported.
- R10: Mode codes 6 and 7 (implicit index) produce `addr` equal to `idx_val`. They make no writeback and no memory request.
- R11: `done` is a one-cycle pulse. `wb_en` is high only in a `done` cycle.
- R12: A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (taken when idle) |
| mode | input | 3 | Addressing-mode code |
| size_word | input | 1 | 1 = word operand, 0 = byte operand |
| next_pc | input | 16 | Address of the next instruction |
| arg | input | 16 | Instruction argument; low byte is the displacement |
| xsub | input | 4 | Indexed sub-mode: [1:0] step, [2] displacement, [3] indirect |
| idx_val | input | 16 | Current index register value |
| mem_req | output | 1 | Pointer word read request |
| mem_addr | output | 16 | Pointer read address |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 16 | Pointer word returned |
| done | output | 1 | Result valid pulse |
| addr | output | 16 | Final operand address (the value itself for literal) |
| wb_en | output | 1 | Index register writeback enable |
| wb_val | output | 16 | Index register writeback value |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle timing and value of the literal, PC-relative and implicit modes, the stability of a pending read request, the hand-off from acknowledge to result, and the confinement of `wb_en` to a one-cycle `done`. Other behaviour is shown only by the bench scenarios. That covers the step size chosen by the operand size, pre-decrement feeding the address, displacement addition, indexed indirection with writeback, wrap-around at both ends of the address space, and a `start` ignored during a slow acknowledge.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int AW = 16;

    typedef enum logic [2:0] {
        M_LIT  = 3'd0,
        M_ABS  = 3'd1,
        M_ABSI = 3'd2,
        M_PCR  = 3'd3,
        M_PCRI = 3'd4,
        M_IDX  = 3'd5,
        M_IMP0 = 3'd6,
        M_IMP1 = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_READ = 2'd1,
        S_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
        logic          wbe;
        logic [AW-1:0] wbv;
    } regs_t;
endpackage

// File: rtl/eag_index_path.sv
module eag_index_path #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] idx,
    input  logic [3:0]    sub,
    input  logic          word,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] ix_addr,
    output logic          ix_ind,
    output logic          ix_wbe,
    output logic [AW-1:0] ix_wbv
);
    localparam int PAD = AW - DW;

    logic [AW-1:0] step, inc, dec, base, offs;

    always_comb begin
        step    = word ? AW'(2) : AW'(1);
        inc     = idx + step;
        dec     = idx - step;
        base    = (sub[1:0] == 2'd2) ? dec : idx;
        offs    = sub[2] ? {{PAD{disp[DW-1]}}, disp} : '0;
        ix_addr = base + offs;
        ix_ind  = sub[3];
        ix_wbe  = (sub[1:0] == 2'd1) || (sub[1:0] == 2'd2);
        ix_wbv  = (sub[1:0] == 2'd1) ? inc : dec;
    end
endmodule

// File: rtl/eag_mode_sel.sv
module eag_mode_sel
    import eag_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] arg,
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] ix_addr,
    input  logic          ix_ind,
    input  logic          ix_wbe,
    input  logic [AW-1:0] ix_wbv,
    output logic [AW-1:0] base,
    output logic          need_rd,
    output logic          wbe,
    output logic [AW-1:0] wbv
);
    localparam int PAD = AW - DW;

    logic [AW-1:0] rel;

    always_comb begin
        rel     = pc + {{PAD{arg[DW-1]}}, arg[DW-1:0]};
        base    = idx;
        need_rd = 1'b0;
        wbe     = 1'b0;
        wbv     = ix_wbv;
        case (mode_e'(mode))
            M_LIT, M_ABS: base = arg;
            M_ABSI: begin
                base    = arg;
                need_rd = 1'b1;
            end
            M_PCR: base = rel;
            M_PCRI: begin
                base    = rel;
                need_rd = 1'b1;
            end
            M_IDX: begin
                base    = ix_addr;
                need_rd = ix_ind;
                wbe     = ix_wbe;
            end
            default: base = idx;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import eag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic          size_word,
    input  logic [15:0]   next_pc,
    input  logic [15:0]   arg,
    input  logic [3:0]    xsub,
    input  logic [15:0]   idx_val,
    output logic          mem_req,
    output logic [15:0]   mem_addr,
    input  logic          mem_ack,
    input  logic [15:0]   mem_rdata,
    output logic          done,
    output logic [15:0]   addr,
    output logic          wb_en,
    output logic [15:0]   wb_val
);
    logic [AW-1:0] ix_addr, ix_wbv, base, wbv;
    logic          ix_ind, ix_wbe, need_rd, wbe, idle;
    regs_t         r_d, r_q;

    eag_index_path #(.AW(AW), .DW(DW)) u_ix (
        .idx(idx_val), .sub(xsub), .word(size_word), .disp(arg[DW-1:0]),
        .ix_addr(ix_addr), .ix_ind(ix_ind), .ix_wbe(ix_wbe), .ix_wbv(ix_wbv)
    );

    eag_mode_sel #(.AW(AW), .DW(DW)) u_sel (
        .mode(mode), .pc(next_pc), .arg(arg), .idx(idx_val),
        .ix_addr(ix_addr), .ix_ind(ix_ind), .ix_wbe(ix_wbe), .ix_wbv(ix_wbv),
        .base(base), .need_rd(need_rd), .wbe(wbe), .wbv(wbv)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: if (start) begin
                r_d.wbe = wbe;
                r_d.wbv = wbv;
                if (need_rd) begin
                    r_d.ptr = base;
                    r_d.st  = S_READ;
                end else begin
                    r_d.addr = base;
                    r_d.st   = S_FIN;
                end
            end
            S_READ: if (mem_ack) begin
                r_d.addr = mem_rdata;
                r_d.st   = S_FIN;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign idle     = (r_q.st == S_IDLE);
    assign done     = (r_q.st == S_FIN);
    assign mem_req  = (r_q.st == S_READ);
    assign mem_addr = r_q.ptr;
    assign addr     = r_q.addr;
    assign wb_en    = done && r_q.wbe;
    assign wb_val   = r_q.wbv;
endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        idle,
    input logic        start,
    input logic [2:0]  mode,
    input logic [15:0] next_pc,
    input logic [15:0] arg,
    input logic [15:0] idx_val,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ack,
    input logic [15:0] mem_rdata,
    input logic        done,
    input logic [15:0] addr,
    input logic        wb_en
);
    logic take;
    assign take = start && idle;

    AST_LIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode == 3'd0 |=> done && !mem_req && addr == $past(arg)); // R2
    AST_ABS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode == 3'd1 |=> done && !mem_req && addr == $past(arg)); // R3
    AST_PCREL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode == 3'd3 |=> done &&
        addr == 16'($past(next_pc) + {{8{$past(arg[7])}}, $past(arg[7:0])})); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R5
    AST_ACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> done && addr == $past(mem_rdata)); // R5
    AST_IMPLICIT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode[2:1] == 2'b11 |=> done && !wb_en && addr == $past(idx_val)); // R10
    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> !done); // R12
endmodule

bind ea_gen ea_gen_checker u_chk (
    .clk(clk), .rst_n(rst_n), .idle(idle), .start(start), .mode(mode),
    .next_pc(next_pc), .arg(arg), .idx_val(idx_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .addr(addr), .wb_en(wb_en)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic        size_word = 1'b0;
    logic [15:0] next_pc = '0, arg = '0, idx_val = '0, mem_rdata = '0;
    logic [3:0]  xsub = '0;
    logic        mem_ack = 1'b0;
    logic        mem_req, done, wb_en;
    logic [15:0] mem_addr, addr, wb_val;

    int total = 0;
    int bad = 0;

    ea_gen u_ea_gen (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [15:0] v);
        return {{8{v[7]}}, v[7:0]};
    endfunction

    function automatic string tag(input logic [2:0] m, input logic [3:0] s);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: begin
                if (s[3]) return "R9";
                if (s[1:0] == 2'd1) return "R7";
                if (s[1:0] == 2'd2) return "R8";
                return "R6";
            end
            default: return "R10";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] m, input logic w, input logic [15:0] pc,
                          input logic [15:0] a, input logic [3:0] s, input logic [15:0] ix,
                          input int dly, input bit disturb);
        logic [15:0] step, b, ea, wv;
        logic        rd, we;
        string       t;
        t    = tag(m, s);
        step = w ? 16'd2 : 16'd1;
        rd   = 1'b0;
        we   = 1'b0;
        wv   = '0;
        case (m)
            3'd0, 3'd1: b = a;
            3'd2: begin b = a; rd = 1'b1; end
            3'd3: b = pc + sx(a);
            3'd4: begin b = pc + sx(a); rd = 1'b1; end
            3'd5: begin
                b = (s[1:0] == 2'd2) ? ix - step : ix;
                if (s[2]) b = b + sx(a);
                rd = s[3];
                we = (s[1:0] == 2'd1) || (s[1:0] == 2'd2);
                wv = (s[1:0] == 2'd1) ? ix + step : ix - step;
            end
            default: b = ix;
        endcase
        ea = b;
        @(negedge clk);
        mode = m; size_word = w; next_pc = pc; arg = a; xsub = s; idx_val = ix;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rd) begin
            chk(mem_req === 1'b1 && done === 1'b0, t, mem_req, 1);
            chk(mem_addr === b, t, mem_addr, b);
            for (int k = 0; k < dly; k++) begin
                if (disturb && k == 0) begin
                    start = 1'b1; mode = 3'd0; arg = ~a;
                end
                @(negedge clk);
                start = 1'b0;
                chk(mem_req === 1'b1 && done === 1'b0 && mem_addr === b,
                    disturb ? "R12" : "R5", mem_addr, b);
            end
            mem_rdata = 16'($urandom);
            ea = mem_rdata;
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
        end else begin
            chk(mem_req === 1'b0, t, mem_req, 0);
        end
        chk(done === 1'b1, t, done, 1);
        chk(addr === ea, t, addr, ea);
        chk(wb_en === we, t, wb_en, we);
        if (we) chk(wb_val === wv, t, wb_val, wv);
        @(negedge clk);
        chk(done === 1'b0 && wb_en === 1'b0, "R11", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && mem_req === 1'b0 && wb_en === 1'b0, "R1", done, 0);
        rst_n = 1'b1;
        // directed corners
        run_op(3'd0, 1, 16'h1234, 16'hBEEF, 4'd0, 16'h0, 0, 0);      // R2
        run_op(3'd1, 0, 16'h1234, 16'h8001, 4'd0, 16'h0, 0, 0);      // R3
        run_op(3'd3, 1, 16'hFFF0, 16'h007F, 4'd0, 16'h0, 0, 0);      // R4 wrap up
        run_op(3'd3, 0, 16'h0010, 16'h0080, 4'd0, 16'h0, 0, 0);      // R4 wrap down
        run_op(3'd2, 1, 16'h0, 16'h4000, 4'd0, 16'h0, 0, 0);         // R5 immediate ack
        run_op(3'd4, 1, 16'h2000, 16'h00FE, 4'd0, 16'h0, 3, 1);      // R5 R12
        run_op(3'd5, 1, 16'h0, 16'h0000, 4'd2, 16'h0000, 0, 0);      // R8 wrap
        run_op(3'd5, 0, 16'h0, 16'h0000, 4'd2, 16'h0005, 0, 0);      // R8 byte
        run_op(3'd5, 1, 16'h0, 16'h0000, 4'd1, 16'hFFFF, 0, 0);      // R7 wrap
        run_op(3'd5, 0, 16'h0, 16'h0000, 4'd1, 16'h0100, 0, 0);      // R7 byte
        run_op(3'd5, 1, 16'h0, 16'h00F0, 4'd6, 16'h1000, 0, 0);      // R8 with disp
        run_op(3'd5, 1, 16'h0, 16'h0010, 4'd7, 16'h1000, 0, 0);      // R6 mode 3 + disp
        run_op(3'd5, 0, 16'h0, 16'h0000, 4'd9, 16'h3000, 2, 1);      // R9 R12
        run_op(3'd6, 1, 16'h0, 16'h1111, 4'd1, 16'h7777, 0, 0);      // R10
        run_op(3'd7, 0, 16'h0, 16'h1111, 4'd2, 16'h8888, 0, 0);      // R10
        // constrained random
        for (int i = 0; i < 400; i++) begin
            run_op(3'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                   4'($urandom), 16'($urandom), int'($urandom % 4), 1'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule